// File: doc/BRIEF.md
# Interrupt-on-Change Detector with Capture

This block watches the synchronised levels of one port of general-purpose pins. It raises an interrupt when an enabled pin moves away from a reference level. Each pin has its own choice of reference. One choice is a fixed level that the host programs. The other is the level the pin had when its last interrupt was taken. When an interrupt is taken, the block stores two things: a flag vector showing which pins caused it, and a snapshot of the whole port at that moment. It then drives an active-high interrupt line.

The host services the interrupt by reading either the snapshot register or the live port register. That read strobe clears the flags, the snapshot and the interrupt line. While an interrupt is waiting to be serviced, the block ignores further pin activity. The flags and the snapshot therefore still describe the first event when the host comes to read them.

Top module: `ioc_detect`

## Requirements
- R1: In reset, and after reset is asserted at any time, the flag vector and the snapshot read as all zeros and the interrupt line is low. The internal reference levels also reset to zero.
- R2: A pin whose `watch_en_i` bit is 0 never sets its flag bit and never causes an interrupt, whatever its level.
- R3: A pin with `watch_en_i`=1 and `cmp_mode_i`=1 (compare-to-default) is an event source whenever its level differs from its `dflt_i` bit. While the pin matches its `dflt_i` bit, it is not an event source.
- R4: A pin with `watch_en_i`=1 and `cmp_mode_i`=0 (compare-to-previous) is an event source whenever its level differs from its stored reference level.
- R5: When an interrupt is taken, each compare-to-previous pin that caused it has its reference set to its current level. A pin that is not enabled in compare-to-previous mode has a reference that follows its level on every cycle. After servicing, a pin that then returns to its earlier level raises a new interrupt. A pin that holds its new level does not.
- R6: Take a clock edge at which no interrupt is pending, no clearing read is present and at least one event source exists. At that edge the flag vector takes the set of event-source pins, the snapshot takes the port level, and `irq_o` is high from that edge on.
- R7: While `irq_o` is high and no clearing read is present, the flag vector and the snapshot do not change, whatever the pins do.
- R8: A high `rd_capture_i` or `rd_port_i` at a clock edge clears the flag vector, the snapshot and `irq_o` at that edge. The clearing read takes priority over any event present at the same edge.
- R9: A compare-to-default mismatch that persists through a clearing read raises the interrupt again at the next clock edge, with the same flag bit set.
- R10: Pins in compare-to-default mode and pins in compare-to-previous mode can share the port. Each pin is judged only by its own mode.
- R11: When several pins are event sources at the same edge, all of their flag bits are set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | W | Synchronised pin levels |
| watch_en_i | input | W | Per-pin interrupt enable |
| dflt_i | input | W | Per-pin default level for compare-to-default mode |
| cmp_mode_i | input | W | Per-pin mode: 1 compare-to-default, 0 compare-to-previous |
| rd_capture_i | input | 1 | Host read strobe of the snapshot register (clears) |
| rd_port_i | input | 1 | Host read strobe of the port register (clears) |
| flags_o | output | W | Pins that caused the pending interrupt |
| snap_o | output | W | Port level captured when the interrupt was taken |
| irq_o | output | 1 | Active-high interrupt line |

## Verification
The hardest case to reach is a compare-to-previous reference that has been moved by a taken interrupt. Driving only the current pin levels cannot reveal it. The stimulus takes an interrupt on a pin, services it, and then returns the pin to its old level to show that a fresh event appears. It also holds a changed pin while an interrupt is pending, so that the change surfaces only after the clearing read. A further sequence keeps a compare-to-default mismatch in place across a clearing read, and checks that the interrupt returns on the very next edge.

// File: rtl/ioc_detect.sv
module ioc_detect #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  input  logic [W-1:0] watch_en_i,
  input  logic [W-1:0] dflt_i,
  input  logic [W-1:0] cmp_mode_i,
  input  logic         rd_capture_i,
  input  logic         rd_port_i,
  output logic [W-1:0] flags_o,
  output logic [W-1:0] snap_o,
  output logic         irq_o
);

  logic [W-1:0] flags_q, snap_q, ref_q;
  logic         irq_q;

  wire          clr  = rd_capture_i | rd_port_i;
  wire [W-1:0]  diff = (cmp_mode_i & (pin_i ^ dflt_i)) | (~cmp_mode_i & (pin_i ^ ref_q));
  wire [W-1:0]  ev   = watch_en_i & diff;
  wire          take = !irq_q && !clr && (|ev);
  wire [W-1:0]  follow = ~(watch_en_i & ~cmp_mode_i);
  wire [W-1:0]  upd  = follow | (take ? ev : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      snap_q  <= '0;
      irq_q   <= 1'b0;
      ref_q   <= '0;
    end else begin
      ref_q <= (pin_i & upd) | (ref_q & ~upd);
      if (clr) begin
        flags_q <= '0;
        snap_q  <= '0;
        irq_q   <= 1'b0;
      end else if (take) begin
        flags_q <= ev;
        snap_q  <= pin_i;
        irq_q   <= 1'b1;
      end
    end
  end

  assign flags_o = flags_q;
  assign snap_o  = snap_q;
  assign irq_o   = irq_q;

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_capture_i || rd_port_i) |=> (flags_o == '0 && snap_o == '0 && !irq_o));

  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !rd_capture_i && !rd_port_i) |=> ($stable(flags_o) && $stable(snap_o)));

  assert_only_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ((flags_o & ~$past(watch_en_i)) == '0));

  assert_snapshot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> (snap_o == $past(pin_i)));

  assert_flags_match_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (flags_o != '0));

  assert_refire_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && !rd_capture_i && !rd_port_i && (|(watch_en_i & cmp_mode_i & (pin_i ^ dflt_i))))
    |=> irq_o);

endmodule

// File: tb/sim_ioc_detect.sv
module sim_ioc_detect;
  localparam int W = 8;
  localparam int N = 22;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] pin_i = '0, watch_en_i = '0, dflt_i = '0, cmp_mode_i = '0;
  logic         rd_capture_i = 1'b0, rd_port_i = 1'b0;
  logic [W-1:0] flags_o, snap_o;
  logic         irq_o;
  int           checks = 0;
  int           errors = 0;
  bit           done = 1'b0;

  always #5 clk = ~clk;

  ioc_detect #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .watch_en_i(watch_en_i),
    .dflt_i(dflt_i), .cmp_mode_i(cmp_mode_i), .rd_capture_i(rd_capture_i),
    .rd_port_i(rd_port_i), .flags_o(flags_o), .snap_o(snap_o), .irq_o(irq_o)
  );

  // {pin, en, dflt, mode, rd_cap, rd_port, exp_flags, exp_snap, exp_irq}
  localparam logic [50:0] VEC [N] = '{
    {8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0},
    {8'hFF, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0},
    {8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0},
    {8'h00, 8'h0F, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0},
    {8'h01, 8'h0F, 8'h00, 8'h00, 1'b0, 1'b0, 8'h01, 8'h01, 1'b1},
    {8'h03, 8'h0F, 8'h00, 8'h00, 1'b0, 1'b0, 8'h01, 8'h01, 1'b1},
    {8'h03, 8'h0F, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0},
    {8'h03, 8'h0F, 8'h00, 8'h00, 1'b0, 1'b0, 8'h02, 8'h03, 1'b1},
    {8'h03, 8'h0F, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00, 8'h00, 1'b0},
    {8'h02, 8'h0F, 8'h00, 8'h00, 1'b0, 1'b0, 8'h01, 8'h02, 1'b1},
    {8'h02, 8'h0F, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0},
    {8'h02, 8'h0F, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0},
    {8'h02, 8'hF0, 8'hA0, 8'hF0, 1'b0, 1'b0, 8'hA0, 8'h02, 1'b1},
    {8'h02, 8'hF0, 8'hA0, 8'hF0, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0},
    {8'h02, 8'hF0, 8'hA0, 8'hF0, 1'b0, 1'b0, 8'hA0, 8'h02, 1'b1},
    {8'hA2, 8'hF0, 8'hA0, 8'hF0, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0},
    {8'hA2, 8'hF0, 8'hA0, 8'hF0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0},
    {8'hA2, 8'h11, 8'h00, 8'h10, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0},
    {8'hB3, 8'h11, 8'h00, 8'h10, 1'b0, 1'b0, 8'h11, 8'hB3, 1'b1},
    {8'hB3, 8'h11, 8'h00, 8'h10, 1'b0, 1'b1, 8'h00, 8'h00, 1'b0},
    {8'hB3, 8'h11, 8'h00, 8'h10, 1'b0, 1'b0, 8'h10, 8'hB3, 1'b1},
    {8'hB3, 8'h11, 8'h00, 8'h10, 1'b1, 1'b0, 8'h00, 8'h00, 1'b0}
  };

  string tags [N] = '{
    "R2", "R2", "R2", "R4", "R4", "R7", "R8", "R4", "R8", "R5", "R8",
    "R5", "R11", "R8", "R9", "R8", "R3", "R10", "R10", "R8", "R10", "R8"
  };

  task automatic check(input string req, input logic [W-1:0] ef,
                       input logic [W-1:0] es, input logic ei);
    checks++;
    if (flags_o !== ef || snap_o !== es || irq_o !== ei) begin
      errors++;
      $display("FAIL %s: flags=%h snap=%h irq=%b, expected flags=%h snap=%h irq=%b",
               req, flags_o, snap_o, irq_o, ef, es, ei);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 8'h00, 8'h00, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 8'h00, 8'h00, 1'b0);

    for (int i = 0; i < N; i++) begin
      {pin_i, watch_en_i, dflt_i, cmp_mode_i, rd_capture_i, rd_port_i} = VEC[i][50:17];
      @(negedge clk);
      check(tags[i], VEC[i][16:9], VEC[i][8:1], VEC[i][0]);
    end

    // R6: snapshot holds the level of the detection edge, not later levels
    rd_capture_i = 1'b0; rd_port_i = 1'b0;
    watch_en_i = 8'h80; cmp_mode_i = 8'h80; dflt_i = 8'h00; pin_i = 8'h85;
    @(negedge clk);
    check("R6", 8'h80, 8'h85, 1'b1);
    pin_i = 8'h00;
    @(negedge clk);
    check("R6", 8'h80, 8'h85, 1'b1);

    // R1: reset during a pending interrupt clears everything
    rst_n = 1'b0;
    #1;
    check("R1", 8'h00, 8'h00, 1'b0);
    @(negedge clk);
    watch_en_i = '0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 8'h00, 8'h00, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule